// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block models a synchronous single-port SRAM whose command interface accepts a read or a write on every clock. Reads and writes may follow each other in any order with no idle cycle between them. All control, address and byte-select inputs are captured on the rising edge. Read data leaves through an output register. Write data trails its command by two clock edges, so the bus turnaround between a read and a write never costs a cycle.

Writes are held in a short pending stage before they reach the array. A read that targets a word with a write still waiting in that stage sees the new bytes merged over the stored ones. A clock-qualify input stalls every stage at once. An internal burst generator lets a command continue the previous operation at the next address within a four-word group, in linear or interleaved order. The shared data bus is modelled as separate input, output and drive-enable signals.

Top module: `zt_sram`

## Requirements
- R1: While `rst_n` is low and after its release with no command, `rdata_oe` is 0 and `rdata` is all zeros.
- R2: A read captured at an edge where `cyc_en` is 1 places the word on `rdata` and raises `rdata_oe` (with `out_en` high) after the second following edge at which `cyc_en` is 1.
- R3: A write takes `wdata` at the second `cyc_en` edge after its command, and updates only lanes whose `cmd_bsel[i]` is 1, where lane i is bits 9i+8 down to 9i.
- R4: Reads and writes on consecutive cycles need no idle cycles, and a read always returns the effect of every earlier write, merged lane by lane.
- R5: A load cycle is a selected command only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Any other pattern is a deselect that writes nothing and leaves `rdata_oe` at 0 at its output slot.
- R6: `rdata_oe` is 0 in the cycle after a write's data edge and after any deselect's output slot.
- R7: `out_en`=0 forces `rdata_oe` to 0 at once, with no clock edge, and `out_en`=1 restores it.
- R8: With `cyc_en`=0 at an edge, no stage advances. `rdata` and `rdata_oe` hold, no write lands, and `wdata` at that edge is ignored.
- R9: With `adv`=1 the cycle repeats the previous operation type, ignores the chip selects and `cmd_addr`, and keeps address bits 7..2. With `burst_ilv`=0 the low two bits are (base + n) mod 4 for the n-th advance after a load.
- R10: With `burst_ilv`=1 the low two bits of the n-th advance are base XOR n.
- R11: An advance that follows a deselect is itself a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | 1 lets the pipeline advance at this edge |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| adv | input | 1 | 1 continues the burst, 0 loads a new command |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| cmd_wr | input | 1 | 1 write, 0 read (load cycles) |
| cmd_addr | input | 8 | Word address (load cycles) |
| cmd_bsel | input | 4 | Byte-lane write selects, one per 9-bit lane |
| out_en | input | 1 | Asynchronous output-drive gate |
| wdata | input | 36 | Write data, two edges after its command |
| rdata | output | 36 | Registered read data |
| rdata_oe | output | 1 | Read-data drive enable |

## Verification
Every result is tied to a count of edges at which `cyc_en` was 1. Read data and its drive enable are due right after the second such edge following the command. Write data must be present at that same second edge. The bench keeps a ring of the last four captured commands indexed by that count, drives `wdata` for the command two slots back, and retires that command in its reference memory after the edge. It compares outputs at the falling edge. Frozen edges do not advance the count and must leave the outputs unchanged. The `out_en` gate is checked a nanosecond after it toggles, with no clock edge.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/zt_sram_burst.sv
module zt_sram_burst
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              adv,
  input  logic              ilv,
  input  logic [ADDR_W-1:0] ld_addr,
  input  op_e               ld_op,
  output op_e               op,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0]  base_q, base_n;
  logic [BURST_W-1:0] cnt_q, cnt_n, cnt_inc, low;
  op_e                prev_q, prev_n;

  assign cnt_inc = cnt_q + 1'b1;
  assign low     = ilv ? (base_q[BURST_W-1:0] ^ cnt_inc)
                       : (base_q[BURST_W-1:0] + cnt_inc);

  always_comb begin
    if (adv) begin
      op     = prev_q;
      addr   = {base_q[ADDR_W-1:BURST_W], low};
      base_n = base_q;
      cnt_n  = cnt_inc;
    end else begin
      op     = ld_op;
      addr   = ld_addr;
      base_n = ld_addr;
      cnt_n  = '0;
    end
    prev_n = op;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      prev_q <= OP_IDLE;
    end else if (en) begin
      base_q <= base_n;
      cnt_q  <= cnt_n;
      prev_q <= prev_n;
    end
  end
endmodule

// File: rtl/zt_sram_store.sv
module zt_sram_store #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     wr_vld,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [LANES-1:0]         wr_bsel,
  input  logic [LANES*LANE_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [LANES*LANE_W-1:0]  rd_word
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              pend_vld_q, pend_vld_n;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [LANES-1:0]  pend_bsel_q;
  logic [DATA_W-1:0] pend_data_q;
  logic              hit;

  assign pend_vld_n = en ? wr_vld : pend_vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_vld_q <= 1'b0;
    else        pend_vld_q <= pend_vld_n;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      pend_addr_q <= wr_addr;
      pend_bsel_q <= wr_bsel;
      pend_data_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (en && pend_vld_q) begin
      for (int l = 0; l < LANES; l++) begin
        if (pend_bsel_q[l]) mem[pend_addr_q][l*LANE_W +: LANE_W] <= pend_data_q[l*LANE_W +: LANE_W];
      end
    end
  end

  assign hit = pend_vld_q && (pend_addr_q == rd_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_word[g*LANE_W +: LANE_W] = (hit && pend_bsel_q[g])
                                         ? pend_data_q[g*LANE_W +: LANE_W]
                                         : mem[rd_addr][g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int LANES   = 4,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cyc_en,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    adv,
  input  logic                    burst_ilv,
  input  logic                    cmd_wr,
  input  logic [ADDR_W-1:0]       cmd_addr,
  input  logic [LANES-1:0]        cmd_bsel,
  input  logic                    out_en,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_oe
);
  localparam int DATA_W = LANES * LANE_W;

  logic              selected;
  op_e               ld_op, cap_op;
  logic [ADDR_W-1:0] cap_addr;

  op_e               s1_op, s1_op_n, s2_op, s2_op_n;
  logic [ADDR_W-1:0] s1_addr, s1_addr_n, s2_addr, s2_addr_n;
  logic [LANES-1:0]  s1_bsel, s1_bsel_n, s2_bsel, s2_bsel_n;

  logic              rd_oe_q, rd_oe_n;
  logic [DATA_W-1:0] rdata_q, rdata_n, rd_word;
  logic              s2_wr, s2_rd;

  assign selected = !sel_a_n && sel_b && !sel_c_n;
  assign ld_op    = selected ? (cmd_wr ? OP_WR : OP_RD) : OP_IDLE;

  zt_sram_burst #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_burst (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (cyc_en),
    .adv     (adv),
    .ilv     (burst_ilv),
    .ld_addr (cmd_addr),
    .ld_op   (ld_op),
    .op      (cap_op),
    .addr    (cap_addr)
  );

  assign s2_wr = (s2_op == OP_WR);
  assign s2_rd = (s2_op == OP_RD);

  zt_sram_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (cyc_en),
    .wr_vld  (s2_wr),
    .wr_addr (s2_addr),
    .wr_bsel (s2_bsel),
    .wr_data (wdata),
    .rd_addr (s2_addr),
    .rd_word (rd_word)
  );

  always_comb begin
    s1_op_n   = s1_op;
    s1_addr_n = s1_addr;
    s1_bsel_n = s1_bsel;
    s2_op_n   = s2_op;
    s2_addr_n = s2_addr;
    s2_bsel_n = s2_bsel;
    rd_oe_n   = rd_oe_q;
    rdata_n   = rdata_q;
    if (cyc_en) begin
      s1_op_n   = cap_op;
      s1_addr_n = cap_addr;
      s1_bsel_n = cmd_bsel;
      s2_op_n   = s1_op;
      s2_addr_n = s1_addr;
      s2_bsel_n = s1_bsel;
      rd_oe_n   = s2_rd;
      if (s2_rd) rdata_n = rd_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op   <= OP_IDLE;
      s1_addr <= '0;
      s1_bsel <= '0;
      s2_op   <= OP_IDLE;
      s2_addr <= '0;
      s2_bsel <= '0;
      rd_oe_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      s1_op   <= s1_op_n;
      s1_addr <= s1_addr_n;
      s1_bsel <= s1_bsel_n;
      s2_op   <= s2_op_n;
      s2_addr <= s2_addr_n;
      s2_bsel <= s2_bsel_n;
      rd_oe_q <= rd_oe_n;
      rdata_q <= rdata_n;
    end
  end

  assign rdata    = rdata_q;
  assign rdata_oe = rd_oe_q && out_en;
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_en,
  input logic              adv,
  input logic              sel_a_n,
  input logic              sel_b,
  input logic              sel_c_n,
  input logic              out_en,
  input logic [DATA_W-1:0] rdata,
  input logic              rdata_oe,
  input logic              rd_oe_q,
  input logic [ADDR_W-1:0] s1_addr,
  input op_e               s2_op
);
  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n) cyc_en && s2_op == OP_RD |=> rd_oe_q); // R2
  AST_WRITE_PHASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) cyc_en && s2_op == OP_WR |=> !rdata_oe); // R6
  AST_DESELECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && !adv && !(!sel_a_n && sel_b && !sel_c_n)) ##1 cyc_en ##1 cyc_en |=> !rd_oe_q); // R5
  AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n) !out_en |-> !rdata_oe); // R7
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !cyc_en |=> $stable(rdata) && $stable(rd_oe_q)); // R8
  AST_BURST_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_en && adv |=> s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2])); // R9
endmodule

bind zt_sram zt_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(LANES*LANE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cyc_en   (cyc_en),
  .adv      (adv),
  .sel_a_n  (sel_a_n),
  .sel_b    (sel_b),
  .sel_c_n  (sel_c_n),
  .out_en   (out_en),
  .rdata    (rdata),
  .rdata_oe (rdata_oe),
  .rd_oe_q  (rd_oe_q),
  .s1_addr  (s1_addr),
  .s2_op    (s2_op)
);

// File: tb/zt_sram_tb_top.sv
`timescale 1ns/1ps
module zt_sram_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cyc_en, sel_a_n, sel_b, sel_c_n, adv, burst_ilv, cmd_wr, out_en;
  logic [7:0]  cmd_addr;
  logic [3:0]  cmd_bsel;
  logic [35:0] wdata, rdata;
  logic        rdata_oe;

  int checks = 0;
  int errors = 0;

  logic [35:0] ref_mem [256];
  int          h_op   [4];
  logic [7:0]  h_addr [4];
  logic [3:0]  h_bsel [4];
  logic [35:0] h_wd   [4];
  int          ecount;
  logic [7:0]  b_base;
  logic [1:0]  b_cnt;
  int          b_prev;
  logic        exp_oe;
  logic [35:0] exp_rd;
  logic [35:0] last_rdata;

  always #4 clk = ~clk;

  zt_sram dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .adv(adv), .burst_ilv(burst_ilv), .cmd_wr(cmd_wr),
    .cmd_addr(cmd_addr), .cmd_bsel(cmd_bsel), .out_en(out_en), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  function automatic logic [35:0] rnd36();
    logic [63:0] t;
    t = {$urandom(), $urandom()};
    return t[35:0];
  endfunction

  function automatic logic [35:0] merge(logic [35:0] old_w, logic [35:0] new_w, logic [3:0] bs);
    logic [35:0] r;
    r = old_w;
    for (int l = 0; l < 4; l++) if (bs[l]) r[l*9 +: 9] = new_w[l*9 +: 9];
    return r;
  endfunction

  task automatic check_eq(string tag, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // One clock: drive at falling edge, model the edge, check at next falling edge.
  task automatic cycle(bit en, bit a, bit wr, bit [2:0] sel, logic [7:0] addr,
                       logic [3:0] bs, bit oe, string tag);
    int e;
    int op;
    int k;
    logic [7:0] ad;
    e = ecount;
    cyc_en = en; adv = a; cmd_wr = wr;
    {sel_a_n, sel_b, sel_c_n} = sel;
    cmd_addr = addr; cmd_bsel = bs; out_en = oe;
    if (en && e >= 2 && h_op[(e-2)%4] == 2) wdata = h_wd[(e-2)%4];
    else wdata = rnd36();
    @(posedge clk);
    if (en) begin
      if (a) begin
        b_cnt = b_cnt + 2'd1;
        ad = {b_base[7:2], burst_ilv ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt)};
        op = b_prev;
      end else begin
        b_base = addr; b_cnt = 2'd0; ad = addr;
        op = (sel == 3'b010) ? (wr ? 2 : 1) : 0;
      end
      b_prev = op;
      h_op[e%4] = op; h_addr[e%4] = ad; h_bsel[e%4] = bs; h_wd[e%4] = rnd36();
      if (e >= 2) begin
        k = (e-2) % 4;
        if (h_op[k] == 2) ref_mem[h_addr[k]] = merge(ref_mem[h_addr[k]], h_wd[k], h_bsel[k]);
        exp_oe = (h_op[k] == 1);
        if (h_op[k] == 1) exp_rd = ref_mem[h_addr[k]];
      end else exp_oe = 1'b0;
      ecount++;
    end
    @(negedge clk);
    check_eq({tag, " drive enable"}, {35'd0, rdata_oe}, {35'd0, exp_oe & oe});
    if (en && exp_oe) check_eq({tag, " read data"}, rdata, exp_rd);
    if (!en) check_eq("R8 frozen data", rdata, last_rdata);
    last_rdata = rdata;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cycle(1, 0, 0, 3'b110, 8'd0, 4'h0, 1, tag);
  endtask

  task automatic wr(logic [7:0] a, logic [3:0] bs, string tag);
    cycle(1, 0, 1, 3'b010, a, bs, 1, tag);
  endtask

  task automatic rd(logic [7:0] a, string tag);
    cycle(1, 0, 0, 3'b010, a, 4'h0, 1, tag);
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; cyc_en = 1'b1; {sel_a_n, sel_b, sel_c_n} = 3'b110; adv = 1'b0;
    burst_ilv = 1'b0; cmd_wr = 1'b0; cmd_addr = '0; cmd_bsel = '0; out_en = 1'b1; wdata = '0;
    ecount = 0; b_base = '0; b_cnt = '0; b_prev = 0; exp_oe = 1'b0; exp_rd = '0;
    for (int i = 0; i < 4; i++) h_op[i] = 0;
    repeat (3) @(negedge clk);
    check_eq("R1 reset drive enable", {35'd0, rdata_oe}, 36'd0);
    check_eq("R1 reset data", rdata, 36'd0);
    rst_n = 1'b1;
    last_rdata = rdata;
    idle(2, "R1");
    check_eq("R1 idle data", rdata, 36'd0);

    for (int a = 0; a < 256; a++) wr(a[7:0], 4'hF, "R3 fill");
    idle(2, "R6");

    rd(8'd5, "R2"); idle(2, "R2");
    rd(8'd6, "R2"); rd(8'd7, "R2"); idle(2, "R2");

    wr(8'd9, 4'b0101, "R3"); idle(2, "R3"); rd(8'd9, "R3"); idle(2, "R3");

    wr(8'd12, 4'b0011, "R4"); rd(8'd12, "R4"); wr(8'd12, 4'b1100, "R4");
    rd(8'd12, "R4"); rd(8'd12, "R4"); wr(8'd13, 4'hF, "R4"); rd(8'd13, "R4"); idle(2, "R4");

    cycle(1, 0, 1, 3'b110, 8'd20, 4'hF, 1, "R5");
    cycle(1, 0, 1, 3'b000, 8'd20, 4'hF, 1, "R5");
    cycle(1, 0, 1, 3'b011, 8'd20, 4'hF, 1, "R5");
    rd(8'd20, "R5"); idle(2, "R5");

    wr(8'd22, 4'hF, "R6"); wr(8'd23, 4'hF, "R6"); rd(8'd22, "R6"); wr(8'd24, 4'hF, "R6"); idle(2, "R6");

    rd(8'd30, "R7"); idle(1, "R7");
    cycle(1, 0, 0, 3'b110, 8'd0, 4'h0, 1, "R7");
    out_en = 1'b0; #1;
    check_eq("R7 gate off", {35'd0, rdata_oe}, 36'd0);
    out_en = 1'b1; #1;
    check_eq("R7 gate on", {35'd0, rdata_oe}, {35'd0, exp_oe});
    idle(1, "R7");

    rd(8'd31, "R8");
    cycle(0, 0, 0, 3'b010, 8'd40, 4'h0, 1, "R8");
    cycle(0, 1, 1, 3'b010, 8'd41, 4'hF, 1, "R8");
    idle(2, "R8");
    wr(8'd32, 4'hF, "R8");
    cycle(0, 0, 1, 3'b010, 8'd33, 4'hF, 1, "R8");
    cycle(0, 0, 1, 3'b010, 8'd33, 4'hF, 1, "R8");
    idle(2, "R8"); rd(8'd32, "R8"); rd(8'd33, "R8"); idle(2, "R8");

    burst_ilv = 1'b0;
    rd(8'h42, "R9");
    for (int i = 0; i < 3; i++) cycle(1, 1, 1, 3'b111, 8'hFF, 4'h0, 1, "R9");
    wr(8'h51, 4'hF, "R9");
    for (int i = 0; i < 3; i++) cycle(1, 1, 0, 3'b000, 8'h00, 4'hF, 1, "R9");
    rd(8'h50, "R9");
    for (int i = 0; i < 3; i++) cycle(1, 1, 0, 3'b010, 8'h00, 4'h0, 1, "R9");
    idle(2, "R9");

    burst_ilv = 1'b1;
    rd(8'h46, "R10");
    for (int i = 0; i < 3; i++) cycle(1, 1, 0, 3'b010, 8'h00, 4'h0, 1, "R10");
    wr(8'h63, 4'hF, "R10");
    for (int i = 0; i < 3; i++) cycle(1, 1, 0, 3'b010, 8'h00, 4'hF, 1, "R10");
    rd(8'h60, "R10");
    for (int i = 0; i < 3; i++) cycle(1, 1, 0, 3'b010, 8'h00, 4'h0, 1, "R10");
    idle(2, "R10");

    cycle(1, 0, 1, 3'b100, 8'h70, 4'hF, 1, "R11");
    cycle(1, 1, 1, 3'b010, 8'h70, 4'hF, 1, "R11");
    cycle(1, 1, 1, 3'b010, 8'h70, 4'hF, 1, "R11");
    idle(2, "R11");
    rd(8'h70, "R11"); rd(8'h71, "R11"); rd(8'h72, "R11"); idle(2, "R11");

    for (int n = 0; n < 3000; n++) begin
      bit en, a, w, oe;
      bit [2:0] s;
      if (n == 1500) burst_ilv = ~burst_ilv;
      en = ($urandom() % 10) != 0;
      a  = ($urandom() % 4) == 0;
      w  = $urandom() % 2;
      oe = ($urandom() % 10) != 0;
      s  = (($urandom() % 7) != 0) ? 3'b010 : 3'($urandom());
      cycle(en, a, w, s, 8'($urandom() % 16), 4'($urandom()), oe, "R4 random");
    end
    idle(3, "R4 drain");

    summary();
    $finish;
  end
endmodule